// File: doc/BRIEF.md
# Reset Controller with Source Capture

This block gathers the chip's hardware reset requests and turns them into a staged set of active-low reset outputs. There are four requests: an active-high power-on request, an active-low qualified external request, an active-low watchdog time-out request and an active-low test reset. The block runs on a slow 32 kHz clock for request handling and on the fast system clock for output staging. The slow domain synchronises every request, notices when each one ends, and combines them into one hard-reset level. The fast domain synchronises that level and releases the peripheral, processor and DRAM-controller resets in a fixed order. The processor reset is released during the low phase of the system clock.

A 16-bit read-only source register tells software which request caused the last hardware reset. When two or more requests end in the same slow-clock cycle, only the highest-priority one is recorded. Power-on ranks highest, then external, then watchdog. When they end in different cycles, the request that ended last is recorded. Only power-on clears the register, so the cause of an external or watchdog reset survives that reset. The processor reads the register over a small select/write/address bus with one cycle of read latency.

Top module: `rstctl_top`

## Requirements
- R1: The source register is one-hot. Bit 0 means power-on, bit 1 means external, bit 2 means watchdog, and bits 15..3 always read as zero.
- R2: A power-on request asserts every hard-reset output at once and clears the source register. When it ends, the register reads 1 (bit 0), unless a lower request is still held and ends later.
- R3: Requests whose synchronised releases fall in the same slow-clock cycle record only the highest one, in the order power-on, external, watchdog.
- R4: Requests released in different slow-clock cycles record the one released last.
- R5: External and watchdog resets never clear the source register. After such a reset, the register holds that request's own bit.
- R6: The peripheral reset is released on a rising system-clock edge, exactly SYS_SYNC rising edges after the slow-domain hard reset ends.
- R7: The processor reset and the reset-out pin are released on the falling system-clock edge that follows the peripheral release. They are never high while the peripheral reset is low.
- R8: The DRAM-controller reset is released DRAM_LAG rising system-clock edges after the peripheral reset, and is never high while that reset is low.
- R9: The core test reset output follows the test reset input level.
- R10: A read strobe (sel_i=1, wr_i=0) at address SRC_OFS (0 by default) returns the source register on rdata_o in the next cycle. Any other address, any write strobe (sel_i=1, wr_i=1) and an idle bus all return zero, and writes leave the register unchanged.
- R11: While any synchronised request is active, the peripheral, processor and DRAM resets stay low.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow_i | input | 1 | 32 kHz request-handling clock |
| clk_sys_i | input | 1 | System clock for output staging and register reads |
| por_i | input | 1 | Power-on request, active high, asynchronous |
| ext_rst_n_i | input | 1 | Qualified external request, active low |
| wdg_rst_n_i | input | 1 | Watchdog time-out request, active low |
| tst_rst_n_i | input | 1 | Test reset request, active low |
| sel_i | input | 1 | Register bus select |
| wr_i | input | 1 | Register bus direction, 1 = write |
| addr_i | input | ADDR_W | Register bus address |
| rdata_o | output | DATA_W | Read data, valid the cycle after a read strobe |
| core_tst_rst_n_o | output | 1 | Debug/trace reset, active low |
| periph_rst_n_o | output | 1 | Peripheral reset (not the watchdog), active low |
| cpu_rst_n_o | output | 1 | Processor and watchdog reset, active low |
| rst_out_n_o | output | 1 | Reset-out pin, copy of the processor reset |
| dram_rst_n_o | output | 1 | DRAM-controller reset, active low |

## Verification
The assertions check several properties on every cycle: the source register never holds more than one bit, and once set it is never cleared without power-on. The processor and DRAM resets are never released ahead of the peripheral reset, and the read bus returns zero whenever no valid read was issued. Other behaviour can only be shown by the bench's scenarios. These include the priority choice between requests that end together, the last-released choice between requests that end apart, the exact release cycle and edge of each output, and the fact that a write strobe leaves the register unchanged.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

   // Bit positions of the cause flags; a lower index means a higher priority.
   localparam int SRC_POR_BIT = 0;
   localparam int SRC_EXT_BIT = 1;
   localparam int SRC_WDG_BIT = 2;
   localparam int SRC_W       = 3;

   typedef logic [SRC_W-1:0] src_vec_t;

   // Choose the new cause from this cycle's release flags.
   // With no release the current value is kept.
   function automatic src_vec_t pick_src(input src_vec_t rel, input src_vec_t cur);
      src_vec_t res;
      res = cur;
      for (int i = SRC_W - 1; i >= 0; i--) begin
         if (rel[i]) res = src_vec_t'(1) << i;
      end
      return res;
   endfunction

endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic arst_i,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstctl_cause.sv
module rstctl_cause
   import rstctl_pkg::*;
#(
   parameter int SLOW_SYNC = 2
) (
   input  logic     clk_slow_i,
   input  logic     por_i,
   input  logic     ext_rst_n_i,
   input  logic     wdg_rst_n_i,
   output logic     hard_n_o,
   output src_vec_t src_o
);

   src_vec_t raw_act;
   src_vec_t act;
   src_vec_t act_d;
   src_vec_t rel;

   always_comb begin
      raw_act              = '0;
      raw_act[SRC_POR_BIT] = por_i;
      raw_act[SRC_EXT_BIT] = ~ext_rst_n_i;
      raw_act[SRC_WDG_BIT] = ~wdg_rst_n_i;
   end

   // Every request is treated as active while power-on holds.
   for (genvar g = 0; g < SRC_W; g++) begin : g_req_sync
      rstctl_sync #(
         .STAGES  (SLOW_SYNC),
         .RST_VAL (1'b1)
      ) u_sync (
         .clk_i  (clk_slow_i),
         .arst_i (por_i),
         .d_i    (raw_act[g]),
         .q_o    (act[g])
      );
   end

   assign rel = act_d & ~act;

   always_ff @(posedge clk_slow_i or posedge por_i) begin
      if (por_i) begin
         act_d    <= '1;
         src_o    <= '0;
         hard_n_o <= 1'b0;
      end else begin
         act_d    <= act;
         src_o    <= pick_src(rel, src_o);
         hard_n_o <= ~|act;
      end
   end

endmodule

// File: rtl/rstctl_stage.sv
module rstctl_stage #(
   parameter int SYS_SYNC = 2,
   parameter int DRAM_LAG = 2
) (
   input  logic clk_sys_i,
   input  logic hard_n_i,
   output logic periph_n_o,
   output logic cpu_n_o,
   output logic dram_n_o
);

   logic arst;
   assign arst = ~hard_n_i;

   // Assert at once, release aligned to a rising system-clock edge.
   rstctl_sync #(
      .STAGES  (SYS_SYNC),
      .RST_VAL (1'b0)
   ) u_sync (
      .clk_i  (clk_sys_i),
      .arst_i (arst),
      .d_i    (1'b1),
      .q_o    (periph_n_o)
   );

   // Half a cycle later, in the clock's low phase.
   always_ff @(negedge clk_sys_i or posedge arst) begin
      if (arst) cpu_n_o <= 1'b0;
      else      cpu_n_o <= periph_n_o;
   end

   if (DRAM_LAG == 0) begin : g_dram_direct
      assign dram_n_o = periph_n_o;
   end else begin : g_dram_lag
      logic [DRAM_LAG-1:0] lag_q;
      logic [DRAM_LAG:0]   lag_in;
      assign lag_in = {lag_q, periph_n_o};
      always_ff @(posedge clk_sys_i or posedge arst) begin
         if (arst) lag_q <= '0;
         else      lag_q <= lag_in[DRAM_LAG-1:0];
      end
      assign dram_n_o = lag_q[DRAM_LAG-1];
   end

endmodule

// File: rtl/rstctl_regrd.sv
module rstctl_regrd
   import rstctl_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 4,
   parameter int SRC_OFS = 0
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  src_vec_t          src_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(SRC_OFS);

   logic              hit;
   logic [DATA_W-1:0] data_d;

   assign hit    = sel_i & ~wr_i & (addr_i == OFS);
   assign data_d = hit ? DATA_W'(src_i) : '0;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) rdata_o <= '0;
      else          rdata_o <= data_d;
   end

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
   import rstctl_pkg::*;
#(
   parameter int SLOW_SYNC    = 2,
   parameter int SYS_SYNC     = 2,
   parameter int DRAM_LAG     = 2,
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 4,
   parameter int SRC_OFS      = 0,
   parameter bit TST_POR_GATE = 1'b0
) (
   input  logic              clk_slow_i,
   input  logic              clk_sys_i,
   input  logic              por_i,
   input  logic              ext_rst_n_i,
   input  logic              wdg_rst_n_i,
   input  logic              tst_rst_n_i,
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              core_tst_rst_n_o,
   output logic              periph_rst_n_o,
   output logic              cpu_rst_n_o,
   output logic              rst_out_n_o,
   output logic              dram_rst_n_o
);

   if (SLOW_SYNC < 2) begin : g_bad_slow_sync
      $error("rstctl_top: SLOW_SYNC must be at least 2");
   end
   if (SYS_SYNC < 2) begin : g_bad_sys_sync
      $error("rstctl_top: SYS_SYNC must be at least 2");
   end
   if (DRAM_LAG < 0) begin : g_bad_lag
      $error("rstctl_top: DRAM_LAG must not be negative");
   end
   if (DATA_W <= SRC_W) begin : g_bad_width
      $error("rstctl_top: DATA_W must exceed the cause width");
   end
   if (ADDR_W < 1 || SRC_OFS < 0 || SRC_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("rstctl_top: SRC_OFS must fit in ADDR_W bits");
   end

   logic     hard_n;
   src_vec_t src_q;

   rstctl_cause #(
      .SLOW_SYNC (SLOW_SYNC)
   ) u_cause (
      .clk_slow_i  (clk_slow_i),
      .por_i       (por_i),
      .ext_rst_n_i (ext_rst_n_i),
      .wdg_rst_n_i (wdg_rst_n_i),
      .hard_n_o    (hard_n),
      .src_o       (src_q)
   );

   rstctl_stage #(
      .SYS_SYNC (SYS_SYNC),
      .DRAM_LAG (DRAM_LAG)
   ) u_stage (
      .clk_sys_i  (clk_sys_i),
      .hard_n_i   (hard_n),
      .periph_n_o (periph_rst_n_o),
      .cpu_n_o    (cpu_rst_n_o),
      .dram_n_o   (dram_rst_n_o)
   );

   assign rst_out_n_o = cpu_rst_n_o;

   // The cause only changes while the processor is held, so it is read directly.
   rstctl_regrd #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .SRC_OFS (SRC_OFS)
   ) u_regrd (
      .clk_i   (clk_sys_i),
      .rst_n_i (periph_rst_n_o),
      .sel_i   (sel_i),
      .wr_i    (wr_i),
      .addr_i  (addr_i),
      .src_i   (src_q),
      .rdata_o (rdata_o)
   );

   if (TST_POR_GATE) begin : g_tst_gated
      assign core_tst_rst_n_o = tst_rst_n_i & ~por_i;
   end else begin : g_tst_plain
      assign core_tst_rst_n_o = tst_rst_n_i;
   end

endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 4,
   parameter int SRC_OFS = 0,
   parameter int SRC_W   = 3
) (
   input logic              clk_slow_i,
   input logic              clk_sys_i,
   input logic              por_i,
   input logic              sel_i,
   input logic              wr_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [DATA_W-1:0] rdata_i,
   input logic [SRC_W-1:0]  src_i,
   input logic              periph_n_i,
   input logic              cpu_n_i,
   input logic              dram_n_i
);

   // R1
   src_onehot_chk: assert property (@(posedge clk_slow_i) disable iff (por_i)
      $onehot0(src_i));

   // R1
   rdata_upper_zero_chk: assert property (@(posedge clk_sys_i) disable iff (por_i)
      rdata_i[DATA_W-1:SRC_W] == '0);

   // R5
   src_kept_chk: assert property (@(posedge clk_slow_i) disable iff (por_i)
      (src_i != '0) |=> (src_i != '0));

   // R7
   cpu_behind_periph_chk: assert property (@(posedge clk_sys_i) disable iff (por_i)
      !periph_n_i |-> !cpu_n_i);

   // R8
   dram_behind_periph_chk: assert property (@(posedge clk_sys_i) disable iff (por_i)
      !periph_n_i |-> !dram_n_i);

   // R10
   idle_read_zero_chk: assert property (@(posedge clk_sys_i) disable iff (por_i)
      !(sel_i && !wr_i && addr_i == ADDR_W'(SRC_OFS)) |=> rdata_i == '0);

endmodule

bind rstctl_top rstctl_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .SRC_OFS (SRC_OFS),
   .SRC_W   (rstctl_pkg::SRC_W)
) u_chk (
   .clk_slow_i (clk_slow_i),
   .clk_sys_i  (clk_sys_i),
   .por_i      (por_i),
   .sel_i      (sel_i),
   .wr_i       (wr_i),
   .addr_i     (addr_i),
   .rdata_i    (rdata_o),
   .src_i      (src_q),
   .periph_n_i (periph_rst_n_o),
   .cpu_n_i    (cpu_rst_n_o),
   .dram_n_i   (dram_rst_n_o)
);

// File: tb/rstctl_top_tb_top.sv
module rstctl_top_tb_top;

   localparam int LAG  = 2;
   localparam int SYNC = 2;

   logic        clk_sys  = 1'b0;
   logic        clk_slow = 1'b0;
   logic        por      = 1'b0;
   logic        ext_n    = 1'b1;
   logic        wdg_n    = 1'b1;
   logic        tst_n    = 1'b0;
   logic        sel      = 1'b0;
   logic        wr       = 1'b0;
   logic [3:0]  addr     = 4'd0;
   logic [15:0] rdata;
   logic        core_n, periph_n, cpu_n, rout_n, dram_n;

   int  vectors  = 0;
   int  miscomp  = 0;
   bit  done     = 1'b0;

   // 50 MHz system clock: rising edges at 10 + 20k ns
   always #10 clk_sys = ~clk_sys;
   // slow clock: rising edges at 5 + 160k ns, never on a system edge
   initial begin
      #5 clk_slow = 1'b1;
      forever #80 clk_slow = ~clk_slow;
   end

   rstctl_top dut_i (
      .clk_slow_i       (clk_slow),
      .clk_sys_i        (clk_sys),
      .por_i            (por),
      .ext_rst_n_i      (ext_n),
      .wdg_rst_n_i      (wdg_n),
      .tst_rst_n_i      (tst_n),
      .sel_i            (sel),
      .wr_i             (wr),
      .addr_i           (addr),
      .rdata_o          (rdata),
      .core_tst_rst_n_o (core_n),
      .periph_rst_n_o   (periph_n),
      .cpu_rst_n_o      (cpu_n),
      .rst_out_n_o      (rout_n),
      .dram_rst_n_o     (dram_n)
   );

   // ---------------- reference model ----------------
   // History of request samples per slow edge, index 0 newest; 1 = active.
   bit          h_p [4] = '{1, 1, 1, 1};
   bit          h_e [4] = '{1, 1, 1, 1};
   bit          h_w [4] = '{1, 1, 1, 1};
   bit [15:0]   m_src  = 16'd0;
   bit          m_hard = 1'b0;
   int          run    = 0;
   bit          m_cpu  = 1'b0;
   bit [15:0]   m_rd   = 16'd0;

   always @(posedge clk_slow or posedge por) begin
      if (por) begin
         for (int i = 0; i < 4; i++) begin
            h_p[i] = 1'b1; h_e[i] = 1'b1; h_w[i] = 1'b1;
         end
         m_src  = 16'd0;
         m_hard = 1'b0;
      end else begin
         for (int i = 3; i > 0; i--) begin
            h_p[i] = h_p[i-1]; h_e[i] = h_e[i-1]; h_w[i] = h_w[i-1];
         end
         h_p[0] = 1'b0;
         h_e[0] = !ext_n;
         h_w[0] = !wdg_n;
         // decision uses samples SYNC and SYNC+1 edges old
         if (h_p[SYNC+1] && !h_p[SYNC])      m_src = 16'd1;
         else if (h_e[SYNC+1] && !h_e[SYNC]) m_src = 16'd2;
         else if (h_w[SYNC+1] && !h_w[SYNC]) m_src = 16'd4;
         m_hard = !(h_p[SYNC] || h_e[SYNC] || h_w[SYNC]);
      end
   end

   always @(posedge clk_sys) begin
      bit pre_p;
      pre_p = m_hard && (run >= SYNC);
      m_rd  = (pre_p && sel && !wr && addr == 4'd0) ? m_src : 16'd0;
      if (!m_hard)        run = 0;
      else if (run < 1000) run = run + 1;
   end

   always @(negedge clk_sys) m_cpu = m_hard && (run >= SYNC);

   // ---------------- checking ----------------
   task automatic cmp(string tag, string what, logic [15:0] act, logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         miscomp++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(posedge clk_sys) begin
      #5;
      if (!done) begin
         bit ep;
         ep = m_hard && (run >= SYNC);
         cmp("R6 R11", "periph", {15'd0, periph_n}, {15'd0, ep});
         cmp("R7", "cpu", {15'd0, cpu_n}, {15'd0, m_hard && m_cpu});
         cmp("R7", "rst_out", {15'd0, rout_n}, {15'd0, m_hard && m_cpu});
         cmp("R8", "dram", {15'd0, dram_n}, {15'd0, m_hard && (run >= SYNC + LAG)});
         cmp("R9", "core_tst", {15'd0, core_n}, {15'd0, tst_n});
         cmp("R10", "rdata", rdata, ep ? m_rd : 16'd0);
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk_sys);
      #11;
   endtask

   task automatic rd_chk(logic [3:0] a, logic w, logic [15:0] exp, string tag);
      sel = 1'b1; wr = w; addr = a;
      @(posedge clk_sys);
      #6;
      cmp(tag, "read", rdata, exp);
      sel = 1'b0; wr = 1'b0; addr = 4'd0;
      #5;
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
   endtask

   initial begin
      #1 por = 1'b1;
      step(20);
      tst_n = 1'b1;
      // R2: power-on alone
      por = 1'b0;
      step(60);
      rd_chk(4'd0, 1'b0, 16'd1, "R2");
      // R10: other address, write strobe, then unchanged content
      rd_chk(4'd5, 1'b0, 16'd0, "R10");
      rd_chk(4'd0, 1'b1, 16'd0, "R10");
      rd_chk(4'd0, 1'b0, 16'd1, "R10");
      // R9: test reset follows input
      tst_n = 1'b0; step(3);
      cmp("R9", "core_tst low", {15'd0, core_n}, 16'd0);
      tst_n = 1'b1; step(3);
      cmp("R9", "core_tst high", {15'd0, core_n}, 16'd1);
      // R11 / R5: external alone
      ext_n = 1'b0; step(40);
      cmp("R11", "periph held", {15'd0, periph_n}, 16'd0);
      cmp("R11", "cpu held", {15'd0, cpu_n}, 16'd0);
      ext_n = 1'b1; step(60);
      rd_chk(4'd0, 1'b0, 16'd2, "R5");
      // R1: watchdog alone
      wdg_n = 1'b0; step(40); wdg_n = 1'b1; step(60);
      rd_chk(4'd0, 1'b0, 16'd4, "R1");
      // R3: external and watchdog end together
      ext_n = 1'b0; wdg_n = 1'b0; step(40);
      ext_n = 1'b1; wdg_n = 1'b1; step(60);
      rd_chk(4'd0, 1'b0, 16'd2, "R3");
      // R4: watchdog ends last
      ext_n = 1'b0; wdg_n = 1'b0; step(40);
      ext_n = 1'b1; step(40); wdg_n = 1'b1; step(60);
      rd_chk(4'd0, 1'b0, 16'd4, "R4");
      // R4: external ends last
      ext_n = 1'b0; wdg_n = 1'b0; step(40);
      wdg_n = 1'b1; step(40); ext_n = 1'b1; step(60);
      rd_chk(4'd0, 1'b0, 16'd2, "R4");
      // R3: power-on and external end together
      por = 1'b1; ext_n = 1'b0; step(20);
      por = 1'b0; ext_n = 1'b1; step(60);
      rd_chk(4'd0, 1'b0, 16'd1, "R3");
      // R4: external outlasts power-on
      por = 1'b1; ext_n = 1'b0; step(20);
      por = 1'b0; step(40); ext_n = 1'b1; step(60);
      rd_chk(4'd0, 1'b0, 16'd2, "R4");
      // R2: power-on outlasts external
      por = 1'b1; ext_n = 1'b0; step(20);
      ext_n = 1'b1; step(40); por = 1'b0; step(60);
      rd_chk(4'd0, 1'b0, 16'd1, "R2");
      // R3: power-on and watchdog end together
      por = 1'b1; wdg_n = 1'b0; step(20);
      por = 1'b0; wdg_n = 1'b1; step(60);
      rd_chk(4'd0, 1'b0, 16'd1, "R3");
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk_sys);
      if (!done) begin
         done = 1'b1;
         miscomp++;
         $display("FAIL R6 watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule